// File: doc/BRIEF.md
# Sensor Frame Region Decoder

This block sits on the digitised sample stream of a single-output interline CCD readout and works out where every sample lies on the full sensor. It uses three strobes to track the column and row of each incoming sample: a per-sample valid, a line boundary and a frame boundary. It then classifies the sample as one of six regions: dummy shift phase or dummy row, shielded dark row, shielded dark column, light-sensitive buffer, active image, or overclock beyond the physical geometry. For active samples it also reports the coordinates inside the 1024 x 1024 image.

As a side function it builds a black-level estimate for each line. It sums the inner 20 columns of the 22-column left dark band and ignores the outermost column at each edge of that band, because light leaks in there. Dummy phases, dark rows and every other column never enter the sum. The mean is published on a registered output at the next line or frame boundary, and only if the line delivered all 20 reference samples. A downstream path uses it for black-level subtraction.

The geometry is set by parameters: dummy phases, dark/buffer widths and heights, and active size. The defaults give 11 dummy phases, 22 dark columns, 8 buffer columns, 1024 active columns, 1 dummy row, 12 dark rows and 8 buffer rows at each edge.

Top module: `frame_region_decoder`

## Requirements
- R1: The sample that arrives in the same cycle as line_start or frame_start is column 0. Each later valid sample advances the column by one, and cycles with pix_valid low do not advance it. A sample with no new line_start continues the current line. The column counter saturates at 1095, so a long line stays in overclock.
- R2: frame_start makes the coincident (or next) line row 0 and takes priority over line_start. A line_start alone advances the row by one, saturating at row 1066.
- R3: Region codes on region_tag are 0 dummy, 1 dark row, 2 dark column, 3 buffer, 4 active, 5 overclock. Columns 0..10 are dummy (0) in every row, and columns 1095 and beyond are overclock (5). In rows 13..1052, columns 11..32 and 1073..1094 are dark column (2), and columns 33..40 and 1065..1072 are buffer (3).
- R4: Rows 0 and 1065 are dummy (0), rows 1..12 and 1053..1064 are dark row (1), and rows 1066 and beyond are overclock (5), for columns 11..1094. Rows 13..20 and 1045..1052 are buffer (3) outside the dark columns.
- R5: A sample in rows 21..1044 and columns 41..1064 is active (4), with act_x = column - 41 and act_y = row - 21. For any other region act_x and act_y are 0.
- R6: out_valid, region_tag, act_x and act_y are registered and appear one cycle after the sample. out_valid is low after a cycle with no sample, and region_tag and the coordinates then hold their last values.
- R7: Only samples tagged dark column in columns 12..31 enter the dark sum. Columns 11 and 32, the right band, dummy phases, dark rows and all other regions never contribute.
- R8: At the clock edge that samples line_start or frame_start, dark_level becomes floor(sum / 20) of the line just ended, but only if that line collected exactly 20 reference samples. Otherwise dark_level holds. dark_level does not change at any other edge.
- R9: A synchronous active-high reset clears out_valid, region_tag, act_x, act_y, dark_level and both position counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | A sample is present this cycle |
| line_start | input | 1 | This cycle begins a new line |
| frame_start | input | 1 | This cycle begins a new frame |
| pix_data | input | DW (12) | Digitised sample |
| out_valid | output | 1 | Registered tag and coordinates belong to a sample |
| region_tag | output | 3 | Region code of the last sample |
| act_x | output | 10 | Column inside the active image |
| act_y | output | 10 | Row inside the active image |
| dark_level | output | DW (12) | Mean of the trusted dark columns of the last complete line |

## Verification
The hardest part to reach from the ports is the bottom of the frame: the last active row, the lower buffer and dark rows, the trailing dummy row and the overclock rows past it. Filling whole lines to get there would cost over a million cycles. The stimulus therefore issues line_start pulses with pix_valid low, which advance the row without any samples, and then streams only as many columns as the probe needs. Dark-level tests place distinct values in the edge dark columns, the right band and the dummy phases, so that any leak into the sum changes the published mean.

// File: rtl/frame_region_decoder.sv
module frame_region_decoder #(
  parameter int DW         = 12,
  parameter int DUMMY_COLS = 11,
  parameter int DARK_COLS  = 22,
  parameter int BUF_COLS   = 8,
  parameter int ACT_W      = 1024,
  parameter int DUMMY_ROWS = 1,
  parameter int DARK_ROWS  = 12,
  parameter int BUF_ROWS   = 8,
  parameter int ACT_H      = 1024
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pix_valid,
  input  logic                     line_start,
  input  logic                     frame_start,
  input  logic [DW-1:0]            pix_data,
  output logic                     out_valid,
  output logic [2:0]               region_tag,
  output logic [$clog2(ACT_W)-1:0] act_x,
  output logic [$clog2(ACT_H)-1:0] act_y,
  output logic [DW-1:0]            dark_level
);

  localparam int C_DL0 = DUMMY_COLS;
  localparam int C_BL0 = C_DL0 + DARK_COLS;
  localparam int C_A0  = C_BL0 + BUF_COLS;
  localparam int C_BR0 = C_A0 + ACT_W;
  localparam int C_DR0 = C_BR0 + BUF_COLS;
  localparam int C_END = C_DR0 + DARK_COLS;

  localparam int R_DK0 = DUMMY_ROWS;
  localparam int R_BT0 = R_DK0 + DARK_ROWS;
  localparam int R_A0  = R_BT0 + BUF_ROWS;
  localparam int R_BB0 = R_A0 + ACT_H;
  localparam int R_DB0 = R_BB0 + BUF_ROWS;
  localparam int R_DM1 = R_DB0 + DARK_ROWS;
  localparam int R_END = R_DM1 + DUMMY_ROWS;

  localparam int CW    = $clog2(C_END + 1);
  localparam int RW    = $clog2(R_END + 1);
  localparam int XW    = $clog2(ACT_W);
  localparam int YW    = $clog2(ACT_H);
  localparam int REF_N = DARK_COLS - 2;
  localparam int NW    = $clog2(REF_N + 1);
  localparam int SW    = DW + NW;

  localparam logic [2:0] TG_DUMMY = 3'd0;
  localparam logic [2:0] TG_DKROW = 3'd1;
  localparam logic [2:0] TG_DKCOL = 3'd2;
  localparam logic [2:0] TG_BUF   = 3'd3;
  localparam logic [2:0] TG_ACT   = 3'd4;
  localparam logic [2:0] TG_OVER  = 3'd5;

  logic [CW-1:0] col_q, col_now, col_nxt;
  logic [RW-1:0] row_q, row_now, row_inc;
  logic [SW-1:0] acc_q;
  logic [NW-1:0] cnt_q;
  logic [DW-1:0] mean;
  logic [2:0]    tag_n;
  logic          boundary, take;
  int            c_i, r_i;

  assign boundary = line_start | frame_start;
  assign col_now  = boundary ? '0 : col_q;
  assign col_nxt  = (col_now == CW'(C_END)) ? col_now : col_now + 1'b1;
  assign row_inc  = (row_q == RW'(R_END)) ? row_q : row_q + 1'b1;
  assign row_now  = frame_start ? '0 : (line_start ? row_inc : row_q);
  assign c_i      = int'(col_now);
  assign r_i      = int'(row_now);

  always_comb begin
    if (c_i < C_DL0)                                    tag_n = TG_DUMMY;
    else if (c_i >= C_END)                              tag_n = TG_OVER;
    else if (r_i < R_DK0 || (r_i >= R_DM1 && r_i < R_END)) tag_n = TG_DUMMY;
    else if (r_i >= R_END)                              tag_n = TG_OVER;
    else if (r_i < R_BT0 || r_i >= R_DB0)               tag_n = TG_DKROW;
    else if (c_i < C_BL0 || c_i >= C_DR0)               tag_n = TG_DKCOL;
    else if (c_i < C_A0 || c_i >= C_BR0 || r_i < R_A0 || r_i >= R_BB0)
                                                        tag_n = TG_BUF;
    else                                                tag_n = TG_ACT;
  end

  assign take = pix_valid && (tag_n == TG_DKCOL) && (c_i > C_DL0) && (c_i < C_BL0 - 1);

  generate
    if (REF_N == 20) begin : g_div20
      localparam int PW = SW + 17;
      assign mean = DW'((PW'(acc_q >> 2) * PW'(52429)) >> 18);
    end else begin : g_divn
      assign mean = DW'(acc_q / SW'(REF_N));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q      <= '0;
      row_q      <= '0;
      acc_q      <= '0;
      cnt_q      <= '0;
      out_valid  <= 1'b0;
      region_tag <= TG_DUMMY;
      act_x      <= '0;
      act_y      <= '0;
      dark_level <= '0;
    end else begin
      col_q     <= pix_valid ? col_nxt : col_now;
      row_q     <= row_now;
      out_valid <= pix_valid;
      if (pix_valid) begin
        region_tag <= tag_n;
        act_x      <= (tag_n == TG_ACT) ? XW'(c_i - C_A0) : '0;
        act_y      <= (tag_n == TG_ACT) ? YW'(r_i - R_A0) : '0;
      end
      if (boundary) begin
        if (cnt_q == NW'(REF_N)) dark_level <= mean;
        acc_q <= '0;
        cnt_q <= '0;
      end else if (take) begin
        acc_q <= acc_q + SW'(pix_data);
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/frame_region_decoder_chk.sv
module frame_region_decoder_chk #(
  parameter int DW = 12,
  parameter int XW = 10,
  parameter int YW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_valid,
  input logic          line_start,
  input logic          frame_start,
  input logic          out_valid,
  input logic [2:0]    region_tag,
  input logic [XW-1:0] act_x,
  input logic [YW-1:0] act_y,
  input logic [DW-1:0] dark_level
);

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> out_valid);

  a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !out_valid);

  a_r6_tag_holds: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> $stable(region_tag) && $stable(act_x) && $stable(act_y));

  a_r3_tag_legal: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> region_tag <= 3'd5);

  a_r5_coords_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && region_tag != 3'd4) |-> (act_x == '0 && act_y == '0));

  a_r1_boundary_col0: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && (line_start || frame_start)) |=> region_tag == 3'd0);

  a_r8_dark_hold: assert property (@(posedge clk) disable iff (rst)
    !(line_start || frame_start) |=> $stable(dark_level));

endmodule

bind frame_region_decoder frame_region_decoder_chk #(
  .DW(DW), .XW(XW), .YW(YW)
) u_chk (
  .clk(clk), .rst(rst), .pix_valid(pix_valid), .line_start(line_start),
  .frame_start(frame_start), .out_valid(out_valid), .region_tag(region_tag),
  .act_x(act_x), .act_y(act_y), .dark_level(dark_level)
);

// File: tb/frame_region_decoder_tb_top.sv
module frame_region_decoder_tb_top;
  localparam int CLK_P = 10;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_valid = 1'b0, line_start = 1'b0, frame_start = 1'b0;
  logic [DW-1:0] pix_data = '0;
  logic out_valid;
  logic [2:0] region_tag;
  logic [9:0] act_x, act_y;
  logic [DW-1:0] dark_level;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  frame_region_decoder dut_i (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .line_start(line_start),
    .frame_start(frame_start), .pix_data(pix_data), .out_valid(out_valid),
    .region_tag(region_tag), .act_x(act_x), .act_y(act_y), .dark_level(dark_level)
  );

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic step(bit v, bit ls, bit fs, int d);
    pix_valid = v; line_start = ls; frame_start = fs; pix_data = DW'(d);
    @(negedge clk);
  endtask

  task automatic start_row(int r);
    step(0, 0, 1, 0);
    for (int k = 1; k < r; k++) step(0, 1, 0, 0);
  endtask

  task automatic probe(int r, int c, int d, int etag, int ex, int ey, string req);
    start_row(r);
    for (int k = 0; k <= c; k++) step(1, k == 0, 0, d);
    chk(req, $sformatf("tag r%0d c%0d", r, c), region_tag, etag);
    chk("R5", $sformatf("x r%0d c%0d", r, c), act_x, ex);
    chk("R5", $sformatf("y r%0d c%0d", r, c), act_y, ey);
  endtask

  task automatic t_reset;
    chk("R9", "out_valid", out_valid, 0);
    chk("R9", "tag", region_tag, 0);
    chk("R9", "dark", dark_level, 0);
    chk("R9", "xy", {act_x, act_y}, 0);
  endtask

  task automatic t_active_row;
    start_row(21);
    for (int c = 0; c < 1100; c++) begin
      step(1, c == 0, 0, (c >= 12 && c <= 31) ? 90 + c : 4095);
      if (c == 0)    chk("R6", "valid", out_valid, 1);
      if (c == 0 || c == 10) chk("R3", $sformatf("c%0d", c), region_tag, 0);
      if (c == 11 || c == 32 || c == 1073 || c == 1094)
        chk("R3", $sformatf("c%0d", c), region_tag, 2);
      if (c == 33 || c == 40 || c == 1065 || c == 1072) begin
        chk("R3", $sformatf("c%0d", c), region_tag, 3);
        chk("R5", $sformatf("x c%0d", c), act_x, 0);
      end
      if (c == 41) begin
        chk("R5", "first active", region_tag, 4);
        chk("R5", "x0", act_x, 0);
        chk("R5", "y0", act_y, 0);
      end
      if (c == 1064) chk("R5", "x last", act_x, 1023);
      if (c == 1095 || c == 1099) chk("R3", $sformatf("c%0d", c), region_tag, 5);
      if (c == 1099) chk("R8", "no mid-line update", dark_level, 0);
    end
    step(0, 0, 0, 0);
    chk("R6", "idle valid", out_valid, 0);
    chk("R6", "tag holds", region_tag, 5);
    chk("R8", "still old", dark_level, 0);
    step(0, 1, 0, 0);
    chk("R7", "mean of inner 20", dark_level, 111);
  endtask

  task automatic t_dark_row;
    start_row(5);
    for (int c = 0; c < 1100; c++) begin
      step(1, c == 0, 0, 7);
      if (c == 5)   chk("R3", "dummy in dark row", region_tag, 0);
      if (c == 11 || c == 20 || c == 600 || c == 1094)
        chk("R4", $sformatf("dark row c%0d", c), region_tag, 1);
      if (c == 1095) chk("R3", "over in dark row", region_tag, 5);
    end
    step(0, 1, 0, 0);
    chk("R7", "dark row ignored", dark_level, 111);
  endtask

  task automatic t_partial;
    start_row(22);
    for (int c = 0; c < 25; c++) step(1, c == 0, 0, 0);
    step(0, 1, 0, 0);
    chk("R8", "partial line holds", dark_level, 111);
  endtask

  task automatic t_update;
    start_row(13);
    for (int c = 0; c <= 50; c++) step(1, c == 0, 0, (c >= 12 && c <= 31) ? 50 : 4000);
    chk("R4", "buffer row", region_tag, 3);
    chk("R8", "before boundary", dark_level, 111);
    step(0, 1, 0, 0);
    chk("R8", "new line mean", dark_level, 50);
  endtask

  task automatic t_gap;
    start_row(30);
    for (int c = 0; c < 50; c++) step(1, c == 0, 0, 0);
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R1", "resume x", act_x, 9);
    chk("R1", "resume y", act_y, 9);
    for (int c = 51; c <= 2000; c++) begin
      step(1, 0, 0, 0);
      if (c == 1095 || c == 2000) chk("R1", $sformatf("sat c%0d", c), region_tag, 5);
    end
  endtask

  task automatic t_frame;
    step(1, 0, 1, 9);
    chk("R2", "frame row0 tag", region_tag, 0);
    for (int k = 0; k < 20; k++) step(0, 1, 0, 0);
    for (int c = 0; c <= 41; c++) step(1, c == 0, 0, 0);
    chk("R2", "row after frame", region_tag, 4);
    chk("R2", "y after frame", act_y, 0);
    chk("R1", "x after frame", act_x, 0);
  endtask

  task automatic t_probes;
    probe(1, 20, 0, 1, 0, 0, "R4");
    probe(12, 20, 0, 1, 0, 0, "R4");
    probe(20, 20, 0, 2, 0, 0, "R3");
    probe(20, 41, 0, 3, 0, 0, "R4");
    probe(1044, 1064, 2000, 4, 1023, 1023, "R5");
    step(0, 0, 1, 0);
    chk("R8", "frame publishes", dark_level, 2000);
    probe(1045, 41, 0, 3, 0, 0, "R4");
    probe(1052, 20, 0, 2, 0, 0, "R3");
    probe(1053, 20, 0, 1, 0, 0, "R4");
    probe(1064, 600, 0, 1, 0, 0, "R4");
    probe(1065, 20, 0, 0, 0, 0, "R4");
    probe(1066, 20, 0, 5, 0, 0, "R4");
    probe(1066, 5, 0, 0, 0, 0, "R3");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_active_row();
    t_dark_row();
    t_partial();
    t_update();
    t_gap();
    t_frame();
    t_probes();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule